// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between instruction fetch and a multi-lane execution pipe. It keeps at most one buffered instruction for each resident warp. Each instruction names up to three source registers and one destination register. Every source and the destination carries its own use flag. A register scoreboard tracks, for each warp, which registers still wait for a result.

A warp is a candidate for issue only when its buffer slot is full and none of the registers its instruction uses has a write pending. Among the candidates, a rotating pointer picks the first one at or after the warp that follows the last one issued. An issued instruction is sent to the execution lanes over several beats. Each beat enables one group of lanes. While a dispatch is in progress no other issue starts. When an instruction with a destination issues, that register is marked pending for that warp. A writeback port clears the mark later.

The control is a two-state machine. WIS_IDLE moves to WIS_DISPATCH when a candidate exists (transition "grant from idle"). In WIS_DISPATCH the beat counter advances each cycle ("beat advance"). On the last beat the machine either starts the next instruction at once and stays in WIS_DISPATCH ("back-to-back grant"), or returns to WIS_IDLE when no candidate is ready ("drain").

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, all buffer slots are empty, `disp_busy` and `issue_start` are 0, `disp_lane_en` is all zero and no register is pending.
- R2: A fill to an empty slot is stored and shows in `slot_full` in the cycle after the fill. A fill naming a warp whose slot is already full is ignored, and the stored instruction stays unchanged.
- R3: A warp whose instruction uses a source register, or a destination register, that is pending for that warp does not issue.
- R4: When an instruction whose destination use flag is set issues, that register becomes pending for the issuing warp only. The same register number in another warp is unaffected.
- R5: A writeback naming a warp and a register clears that pending mark. A warp stalled only on that mark then issues.
- R6: Among eligible warps, the one chosen is the first at or after the warp that follows the last issued warp, wrapping from the highest warp index to 0.
- R7: A dispatch lasts DISPATCH_CYCLES cycles, with `disp_beat` counting 0 upward. In beat b, `disp_lane_en` enables only lanes b*LANES/DISPATCH_CYCLES up to (b+1)*LANES/DISPATCH_CYCLES-1. Starts of successive issues are at least DISPATCH_CYCLES cycles apart, and exactly that far apart when a candidate is waiting.
- R8: A warp stalled on the scoreboard does not prevent other eligible warps from issuing.
- R9: When a writeback clear and an issue's pending mark hit the same warp and register in the same cycle, the register ends up pending.
- R10: In the first dispatch cycle `issue_start` is 1 and `disp_warp` names the issued warp, and that warp's slot reads empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill request this cycle |
| fill_warp | input | WW | Warp whose slot the fill targets |
| fill_src_idx | input | NUM_SRCS*RW | Source register numbers, source 0 in the low bits |
| fill_src_use | input | NUM_SRCS | Per-source use flags, bit s for source s |
| fill_dst_idx | input | RW | Destination register number |
| fill_dst_use | input | 1 | Destination use flag |
| wb_valid | input | 1 | Writeback clear request |
| wb_warp | input | WW | Warp of the writeback |
| wb_reg | input | RW | Register whose pending mark is cleared |
| slot_full | output | NUM_WARPS | Per-warp buffer occupancy |
| issue_start | output | 1 | First beat of a new dispatch |
| disp_busy | output | 1 | A dispatch is in progress |
| disp_warp | output | WW | Warp being dispatched |
| disp_src_idx | output | NUM_SRCS*RW | Source numbers of the dispatched instruction |
| disp_src_use | output | NUM_SRCS | Source use flags of the dispatched instruction |
| disp_dst_idx | output | RW | Destination of the dispatched instruction |
| disp_dst_use | output | 1 | Destination use flag of the dispatched instruction |
| disp_beat | output | BW | Current beat of the dispatch |
| disp_lane_en | output | LANES | Lanes driven in this beat |

## Verification
The bench uses the default parameters: 24 warps, 16 registers per warp, three sources, 32 lanes and four beats per dispatch. With 24 warps the bench can place the rotating pointer near the top index and show the wrap from warp 23 to a low warp. With four beats there is room to fill three more warps during one dispatch, so the order among several waiting candidates is visible. The scoreboard cases cover a stall on a source, a stall on a destination, and a clear that lands in the same cycle as the mark it races.

// File: rtl/wis_pkg.sv
package wis_pkg;
    typedef enum logic [0:0] {
        WIS_IDLE     = 1'b0,
        WIS_DISPATCH = 1'b1
    } wis_state_e;
endpackage

// File: rtl/wis_instr_buf.sv
// One instruction slot per warp; a slot loads only while empty and
// is released when its warp is granted.
module wis_instr_buf #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_SRCS  = 3,
    parameter int RW        = 4,
    parameter int WW        = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_valid,
    input  logic [WW-1:0]            fill_warp,
    input  logic [NUM_SRCS*RW-1:0]   fill_src_idx,
    input  logic [NUM_SRCS-1:0]      fill_src_use,
    input  logic [RW-1:0]            fill_dst_idx,
    input  logic                     fill_dst_use,
    input  logic                     take_en,
    input  logic [WW-1:0]            take_warp,
    output logic [NUM_WARPS-1:0]     valid,
    output logic [NUM_SRCS*RW-1:0]   src_idx [NUM_WARPS],
    output logic [NUM_SRCS-1:0]      src_use [NUM_WARPS],
    output logic [RW-1:0]            dst_idx [NUM_WARPS],
    output logic                     dst_use [NUM_WARPS]
);
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        logic hit_fill;
        logic hit_take;
        assign hit_fill = fill_valid && (fill_warp == WW'(w)) && !valid[w];
        assign hit_take = take_en && (take_warp == WW'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[w]   <= 1'b0;
                src_idx[w] <= '0;
                src_use[w] <= '0;
                dst_idx[w] <= '0;
                dst_use[w] <= 1'b0;
            end else if (hit_take) begin
                valid[w] <= 1'b0;
            end else if (hit_fill) begin
                valid[w]   <= 1'b1;
                src_idx[w] <= fill_src_idx;
                src_use[w] <= fill_src_use;
                dst_idx[w] <= fill_dst_idx;
                dst_use[w] <= fill_dst_use;
            end
        end
    end
endmodule

// File: rtl/wis_scoreboard.sv
// Pending-write bits per warp and register; a set beats a clear.
module wis_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 16,
    parameter int RW        = 4,
    parameter int WW        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [WW-1:0]        set_warp,
    input  logic [RW-1:0]        set_reg,
    input  logic                 clr_en,
    input  logic [WW-1:0]        clr_warp,
    input  logic [RW-1:0]        clr_reg,
    output logic [NUM_REGS-1:0]  pend [NUM_WARPS]
);
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_REGS-1:0] set_mask;
        logic [NUM_REGS-1:0] clr_mask;

        always_comb begin
            set_mask = '0;
            clr_mask = '0;
            if (set_en && set_warp == WW'(w)) set_mask[set_reg] = 1'b1;
            if (clr_en && clr_warp == WW'(w)) clr_mask[clr_reg] = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) pend[w] <= '0;
            else        pend[w] <= (pend[w] & ~clr_mask) | set_mask;
        end
    end
endmodule

// File: rtl/wis_rr_pick.sv
// Picks the first requester at or after the pointer, wrapping.
module wis_rr_pick #(
    parameter int N  = 24,
    parameter int WW = 5
) (
    input  logic [N-1:0]  req,
    input  logic [WW-1:0] ptr,
    output logic          gnt_valid,
    output logic [WW-1:0] gnt_idx
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= N) idx = idx - N;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_idx   = WW'(idx);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS       = 24,
    parameter int NUM_REGS        = 16,
    parameter int NUM_SRCS        = 3,
    parameter int LANES           = 32,
    parameter int DISPATCH_CYCLES = 4,
    localparam int WW  = $clog2(NUM_WARPS),
    localparam int RW  = $clog2(NUM_REGS),
    localparam int BW  = (DISPATCH_CYCLES > 1) ? $clog2(DISPATCH_CYCLES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_valid,
    input  logic [WW-1:0]           fill_warp,
    input  logic [NUM_SRCS*RW-1:0]  fill_src_idx,
    input  logic [NUM_SRCS-1:0]     fill_src_use,
    input  logic [RW-1:0]           fill_dst_idx,
    input  logic                    fill_dst_use,
    input  logic                    wb_valid,
    input  logic [WW-1:0]           wb_warp,
    input  logic [RW-1:0]           wb_reg,
    output logic [NUM_WARPS-1:0]    slot_full,
    output logic                    issue_start,
    output logic                    disp_busy,
    output logic [WW-1:0]           disp_warp,
    output logic [NUM_SRCS*RW-1:0]  disp_src_idx,
    output logic [NUM_SRCS-1:0]     disp_src_use,
    output logic [RW-1:0]           disp_dst_idx,
    output logic                    disp_dst_use,
    output logic [BW-1:0]           disp_beat,
    output logic [LANES-1:0]        disp_lane_en
);
    import wis_pkg::*;

    localparam int LANES_PER_BEAT = LANES / DISPATCH_CYCLES;
    localparam logic [BW-1:0] LAST_BEAT = BW'(DISPATCH_CYCLES - 1);

    // slot contents
    logic [NUM_SRCS*RW-1:0] b_src_idx [NUM_WARPS];
    logic [NUM_SRCS-1:0]    b_src_use [NUM_WARPS];
    logic [RW-1:0]          b_dst_idx [NUM_WARPS];
    logic                   b_dst_use [NUM_WARPS];

    // scoreboard
    logic [NUM_REGS-1:0]    pend [NUM_WARPS];
    logic [NUM_WARPS*NUM_REGS-1:0] pend_flat;

    // selection
    logic [NUM_WARPS-1:0]   eligible;
    logic                   pick_valid;
    logic [WW-1:0]          pick_idx;
    logic [WW-1:0]          rr_ptr_q;
    logic                   can_grant;
    logic                   grant;

    // state machine
    wis_state_e             state_q, state_d;
    logic [BW-1:0]          beat_q, beat_d;

    wis_instr_buf #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_SRCS  (NUM_SRCS),
        .RW        (RW),
        .WW        (WW)
    ) buf_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_warp    (fill_warp),
        .fill_src_idx (fill_src_idx),
        .fill_src_use (fill_src_use),
        .fill_dst_idx (fill_dst_idx),
        .fill_dst_use (fill_dst_use),
        .take_en      (grant),
        .take_warp    (pick_idx),
        .valid        (slot_full),
        .src_idx      (b_src_idx),
        .src_use      (b_src_use),
        .dst_idx      (b_dst_idx),
        .dst_use      (b_dst_use)
    );

    wis_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS),
        .RW        (RW),
        .WW        (WW)
    ) sb_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (grant && b_dst_use[pick_idx]),
        .set_warp (pick_idx),
        .set_reg  (b_dst_idx[pick_idx]),
        .clr_en   (wb_valid),
        .clr_warp (wb_warp),
        .clr_reg  (wb_reg),
        .pend     (pend)
    );

    // eligibility: slot full and no used operand pending
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
        assign pend_flat[w*NUM_REGS +: NUM_REGS] = pend[w];

        always_comb begin
            eligible[w] = slot_full[w];
            for (int s = 0; s < NUM_SRCS; s++) begin
                if (b_src_use[w][s] && pend[w][b_src_idx[w][s*RW +: RW]])
                    eligible[w] = 1'b0;
            end
            if (b_dst_use[w] && pend[w][b_dst_idx[w]])
                eligible[w] = 1'b0;
        end
    end

    wis_rr_pick #(
        .N  (NUM_WARPS),
        .WW (WW)
    ) pick_i (
        .req       (eligible),
        .ptr       (rr_ptr_q),
        .gnt_valid (pick_valid),
        .gnt_idx   (pick_idx)
    );

    assign can_grant = (state_q == WIS_IDLE) || (beat_q == LAST_BEAT);
    assign grant     = can_grant && pick_valid;

    // next state
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            WIS_IDLE: begin
                if (grant) begin
                    state_d = WIS_DISPATCH;
                    beat_d  = '0;
                end
            end
            WIS_DISPATCH: begin
                if (beat_q == LAST_BEAT) begin
                    beat_d = '0;
                    if (!grant) state_d = WIS_IDLE;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIS_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // dispatch output registers and rotating pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_warp    <= '0;
            disp_src_idx <= '0;
            disp_src_use <= '0;
            disp_dst_idx <= '0;
            disp_dst_use <= 1'b0;
            rr_ptr_q     <= '0;
        end else if (grant) begin
            disp_warp    <= pick_idx;
            disp_src_idx <= b_src_idx[pick_idx];
            disp_src_use <= b_src_use[pick_idx];
            disp_dst_idx <= b_dst_idx[pick_idx];
            disp_dst_use <= b_dst_use[pick_idx];
            rr_ptr_q     <= (pick_idx == WW'(NUM_WARPS - 1)) ? '0 : pick_idx + 1'b1;
        end
    end

    assign disp_busy   = (state_q == WIS_DISPATCH);
    assign disp_beat   = beat_q;
    assign issue_start = disp_busy && (beat_q == '0);

    for (genvar g = 0; g < DISPATCH_CYCLES; g++) begin : g_lanes
        assign disp_lane_en[g*LANES_PER_BEAT +: LANES_PER_BEAT] =
            {LANES_PER_BEAT{disp_busy && (beat_q == BW'(g))}};
    end
endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
    parameter int NUM_WARPS       = 24,
    parameter int NUM_REGS        = 16,
    parameter int LANES           = 32,
    parameter int DISPATCH_CYCLES = 4,
    parameter int WW              = 5,
    parameter int RW              = 4,
    parameter int BW              = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_WARPS-1:0]          slot_full,
    input logic                          issue_start,
    input logic                          disp_busy,
    input logic [WW-1:0]                 disp_warp,
    input logic [RW-1:0]                 disp_dst_idx,
    input logic                          disp_dst_use,
    input logic [BW-1:0]                 disp_beat,
    input logic [LANES-1:0]              disp_lane_en,
    input logic [NUM_WARPS*NUM_REGS-1:0] pend_flat
);
    localparam logic [BW-1:0] LAST = BW'(DISPATCH_CYCLES - 1);
    localparam int LPB = LANES / DISPATCH_CYCLES;

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_busy && disp_beat != LAST) |=> (disp_busy && disp_beat == $past(disp_beat) + 1'b1));

    // R7
    lane_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_busy |-> ($countones(disp_lane_en) == LPB));

    // R7
    lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_busy |-> (disp_lane_en == '0));

    // R7
    issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_start |-> ($past(!disp_busy) || $past(disp_beat) == LAST));

    // R10
    slot_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_start |-> !slot_full[disp_warp]);

    // R4
    dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_start && disp_dst_use) |-> pend_flat[int'(disp_warp)*NUM_REGS + int'(disp_dst_idx)]);

    // R7
    warp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_busy && disp_beat != '0) |-> $stable(disp_warp));
endmodule

bind warp_issue_sched wis_chk #(
    .NUM_WARPS       (NUM_WARPS),
    .NUM_REGS        (NUM_REGS),
    .LANES           (LANES),
    .DISPATCH_CYCLES (DISPATCH_CYCLES),
    .WW              (WW),
    .RW              (RW),
    .BW              (BW)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_full    (slot_full),
    .issue_start  (issue_start),
    .disp_busy    (disp_busy),
    .disp_warp    (disp_warp),
    .disp_dst_idx (disp_dst_idx),
    .disp_dst_use (disp_dst_use),
    .disp_beat    (disp_beat),
    .disp_lane_en (disp_lane_en),
    .pend_flat    (pend_flat)
);

// File: tb/warp_issue_sched_tb_top.sv
`timescale 1ns/1ps
module warp_issue_sched_tb_top;
    localparam int NW = 24;
    localparam int WW = 5;
    localparam int RW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fill_valid = 1'b0;
    logic [WW-1:0]   fill_warp = '0;
    logic [11:0]     fill_src_idx = '0;
    logic [2:0]      fill_src_use = '0;
    logic [RW-1:0]   fill_dst_idx = '0;
    logic            fill_dst_use = 1'b0;
    logic            wb_valid = 1'b0;
    logic [WW-1:0]   wb_warp = '0;
    logic [RW-1:0]   wb_reg = '0;
    logic [NW-1:0]   slot_full;
    logic            issue_start;
    logic            disp_busy;
    logic [WW-1:0]   disp_warp;
    logic [11:0]     disp_src_idx;
    logic [2:0]      disp_src_use;
    logic [RW-1:0]   disp_dst_idx;
    logic            disp_dst_use;
    logic [1:0]      disp_beat;
    logic [31:0]     disp_lane_en;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int log_n = 0;
    int log_warp [64];
    int log_cyc  [64];
    int log_duse [64];
    int log_src0 [64];

    always #2.5 clk = ~clk;

    warp_issue_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_warp(fill_warp),
        .fill_src_idx(fill_src_idx), .fill_src_use(fill_src_use),
        .fill_dst_idx(fill_dst_idx), .fill_dst_use(fill_dst_use),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .slot_full(slot_full), .issue_start(issue_start), .disp_busy(disp_busy),
        .disp_warp(disp_warp), .disp_src_idx(disp_src_idx), .disp_src_use(disp_src_use),
        .disp_dst_idx(disp_dst_idx), .disp_dst_use(disp_dst_use),
        .disp_beat(disp_beat), .disp_lane_en(disp_lane_en)
    );

    // issue monitor, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        if (rst_n && issue_start && log_n < 64) begin
            log_warp[log_n] = int'(disp_warp);
            log_cyc[log_n]  = cyc;
            log_duse[log_n] = int'(disp_dst_use);
            log_src0[log_n] = int'(disp_src_idx[3:0]);
            log_n = log_n + 1;
        end
        if (cyc > 20000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_fill(input int w, input logic [3:0] s0, input logic [2:0] su,
                           input logic [3:0] d, input logic du);
        fill_valid   = 1'b1;
        fill_warp    = WW'(w);
        fill_src_idx = {8'h00, s0};
        fill_src_use = su;
        fill_dst_idx = d;
        fill_dst_use = du;
        @(negedge clk);
        fill_valid   = 1'b0;
    endtask

    task automatic do_wb(input int w, input logic [3:0] r);
        wb_valid = 1'b1;
        wb_warp  = WW'(w);
        wb_reg   = r;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(slot_full == '0, "R1 slots empty", int'(slot_full), 0);
        chk(!disp_busy && !issue_start, "R1 no dispatch", int'(disp_busy), 0);
        chk(disp_lane_en == '0, "R1 lanes off", int'(disp_lane_en), 0);
    endtask

    task automatic t_basic();
        int base;
        base = log_n;
        do_fill(3, 4'd0, 3'b000, 4'd5, 1'b1);
        chk(slot_full[3] == 1'b1, "R2 slot loaded", int'(slot_full[3]), 1);
        @(negedge clk);
        chk(issue_start && disp_warp == 5'd3, "R10 issue warp", int'(disp_warp), 3);
        chk(slot_full[3] == 1'b0, "R10 slot released", int'(slot_full[3]), 0);
        for (int b = 0; b < 4; b++) begin
            chk(disp_busy && disp_beat == 2'(b) && disp_lane_en == (32'hFF << (8*b)),
                "R7 beat lanes", int'(disp_lane_en), int'(32'hFF << (8*b)));
            @(negedge clk);
        end
        chk(!disp_busy, "R7 dispatch ends", int'(disp_busy), 0);
        chk(log_n == base + 1, "R7 single issue", log_n - base, 1);
    endtask

    task automatic t_stall();
        int base;
        // warp 3 has r5 pending from t_basic
        base = log_n;
        do_fill(3, 4'd5, 3'b001, 4'd0, 1'b0);
        idle(8);
        chk(log_n == base && slot_full[3], "R3 source stall", log_n - base, 0);
        do_fill(4, 4'd5, 3'b001, 4'd0, 1'b0);
        idle(6);
        chk(log_n == base + 1 && log_warp[base] == 4, "R8 other warp issues",
            log_warp[base], 4);
        chk(log_n == base + 1, "R4 mark is per warp", log_n - base, 1);
        do_wb(3, 4'd5);
        idle(6);
        chk(log_n == base + 2 && log_warp[base+1] == 3, "R5 cleared warp issues",
            log_warp[base+1], 3);
        // destination hazard
        base = log_n;
        do_fill(6, 4'd0, 3'b000, 4'd2, 1'b1);
        idle(6);
        do_fill(6, 4'd0, 3'b000, 4'd2, 1'b1);
        idle(8);
        chk(log_n == base + 1, "R3 destination stall", log_n - base, 1);
        do_wb(6, 4'd2);
        idle(6);
        chk(log_n == base + 2 && log_warp[base+1] == 6, "R5 dst clear issues",
            log_warp[base+1], 6);
        do_wb(6, 4'd2);
        idle(2);
    endtask

    task automatic t_ignore();
        int base;
        base = log_n;
        do_fill(8, 4'd0, 3'b000, 4'd7, 1'b1);
        idle(6);
        do_fill(8, 4'd7, 3'b001, 4'd0, 1'b0);
        do_fill(8, 4'd0, 3'b000, 4'd9, 1'b1);
        idle(4);
        chk(log_n == base + 1, "R2 held while stalled", log_n - base, 1);
        do_wb(8, 4'd7);
        idle(6);
        chk(log_n == base + 2 && log_duse[base+1] == 0 && log_src0[base+1] == 7,
            "R2 full slot fill ignored", log_src0[base+1], 7);
        idle(6);
        chk(log_n == base + 2 && !slot_full[8], "R2 no second copy", log_n - base, 2);
    endtask

    task automatic t_rr();
        int base;
        base = log_n;
        do_fill(5, 4'd0, 3'b000, 4'd0, 1'b0);
        do_fill(2, 4'd0, 3'b000, 4'd0, 1'b0);
        do_fill(9, 4'd0, 3'b000, 4'd0, 1'b0);
        do_fill(7, 4'd0, 3'b000, 4'd0, 1'b0);
        idle(20);
        chk(log_n == base + 4, "R6 four issues", log_n - base, 4);
        chk(log_warp[base] == 5 && log_warp[base+1] == 7, "R6 order after 5",
            log_warp[base+1], 7);
        chk(log_warp[base+2] == 9 && log_warp[base+3] == 2, "R6 order wraps",
            log_warp[base+3], 2);
        for (int k = 1; k < 4; k++)
            chk(log_cyc[base+k] - log_cyc[base+k-1] == 4, "R7 back-to-back spacing",
                log_cyc[base+k] - log_cyc[base+k-1], 4);
        base = log_n;
        do_fill(22, 4'd0, 3'b000, 4'd0, 1'b0);
        do_fill(1, 4'd0, 3'b000, 4'd0, 1'b0);
        do_fill(23, 4'd0, 3'b000, 4'd0, 1'b0);
        idle(16);
        chk(log_n == base + 3 && log_warp[base+1] == 23 && log_warp[base+2] == 1,
            "R6 wrap top to low", log_warp[base+2], 1);
    endtask

    task automatic t_collide();
        int base;
        base = log_n;
        do_fill(10, 4'd0, 3'b000, 4'd3, 1'b1);
        // grant of warp 10 happens at the next edge; clear races it
        do_wb(10, 4'd3);
        idle(5);
        chk(log_n == base + 1, "R9 first issue", log_n - base, 1);
        do_fill(10, 4'd3, 3'b001, 4'd0, 1'b0);
        idle(8);
        chk(log_n == base + 1, "R9 set wins over clear", log_n - base, 1);
        do_wb(10, 4'd3);
        idle(6);
        chk(log_n == base + 2 && log_warp[base+1] == 10, "R5 late clear",
            log_warp[base+1], 10);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_ignore();
        t_rr();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule